// File: doc/BRIEF.md
# Periodic Conversion Trigger Timer

This block paces an A/D queue controller. A counter advances on each cycle where the prescaled conversion-clock enable is high. When the count reaches the end of a programmable power-of-two period, the counter wraps to zero and the block raises a one-clock trigger pulse. The queue controller uses that pulse to start a scan. The current count is also visible at the ports.

The block follows a debug freeze request. The request counts only when the freeze-enable control bit is set and timer mode is selected. The block handles the request in one of two ways:
- If no conversion is in flight, the counter is cleared at once and held at zero.
- If the converter reports a conversion in progress, the counter keeps running without issuing triggers. It is cleared and held only once the conversion finishes.

When the freeze line drops, counting restarts from zero.

Top module: `conv_trig_timer`

## Requirements
- R1: A synchronous active-high reset clears the count and the trigger output, and discards any pending deferred clear. After reset the timer counts normally.
- R2: The count changes only on cycles where `qclk_en` is high, incrementing by one. On other cycles it holds its value, unless a clear condition from R5, R6, R7 or R8 applies.
- R3: With `period_code` = c, the period is 2^(MIN_EXP+c) enables. On the enable where the count equals the last value of the period, the count wraps to 0, and `trig` is high for exactly the one cycle in which the count first reads 0.
- R4: While `frz_en` is 0, `sys_frz` has no effect on the count or on `trig`.
- R5: A freeze request arrives when `frz_en`, `sys_frz` and `mode_timer` are all 1. If it is seen while `conv_busy` is 0, the count reads 0 on the next cycle. It stays at 0 with `trig` low for as long as the request lasts.
- R6: If a freeze request is seen while `conv_busy` is 1, the count keeps advancing on enables, including wrapping, but no trigger is issued. On the first edge where `conv_busy` is 0, the count is cleared. It is then held at 0 as in R5.
- R7: On the edge where a held or deferred freeze request is seen negated, the count reads 0. Each following enable increments it from 0.
- R8: While `mode_timer` is 0, the count is held at 0 and `trig` stays low. Once `mode_timer` returns to 1, counting resumes from 0.
- R9: If `period_code` is lowered so that the count is already at or above the new last value, the next enable wraps the count to 0 and raises `trig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qclk_en | input | 1 | Prescaled conversion-clock enable |
| mode_timer | input | 1 | 1 = periodic/interval timer mode selected |
| period_code | input | CODE_W | Period exponent offset |
| frz_en | input | 1 | Freeze-enable control bit |
| sys_frz | input | 1 | System debug freeze line |
| conv_busy | input | 1 | Converter has a conversion in progress |
| trig | output | 1 | One-clock conversion trigger |
| count | output | CNT_W | Current timer count |

## Verification
A wrong freeze state shows at the ports within one edge. Depending on the fault, the count fails to read zero, keeps advancing while it should be held, or is cleared while a conversion is still running. It also shows as a trigger pulse during a deferred freeze.

A wrong period limit or a stuck enable shows in the count on the next enable. It also shifts the trigger away from the enable number that is a multiple of the period. The sweep therefore compares the count and the trigger on every cycle, across all period codes and several enable spacings.

// File: rtl/trig_tmr_pkg.sv
package trig_tmr_pkg;

    typedef enum logic [1:0] {
        FZ_RUN   = 2'd0,
        FZ_DEFER = 2'd1,
        FZ_HOLD  = 2'd2
    } frz_state_e;

    typedef struct packed {
        logic clr;
        logic fire_ok;
    } frz_ctl_t;

    function automatic int period_exp(input int min_exp, input int code);
        return min_exp + code;
    endfunction

endpackage

// File: rtl/trig_frz_ctl.sv
module trig_frz_ctl
    import trig_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frz_act,
    input  logic       conv_busy,
    input  logic       mode_timer,
    output frz_state_e state,
    output frz_ctl_t   ctl
);
    frz_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FZ_RUN:   if (frz_act) state_d = conv_busy ? FZ_DEFER : FZ_HOLD;
            FZ_DEFER: begin
                if (!frz_act)       state_d = FZ_RUN;
                else if (!conv_busy) state_d = FZ_HOLD;
            end
            FZ_HOLD:  if (!frz_act) state_d = FZ_RUN;
            default:  state_d = FZ_RUN;
        endcase
    end

    always_comb begin
        ctl.clr = !mode_timer;
        unique case (state_q)
            FZ_RUN:   if (frz_act && !conv_busy) ctl.clr = 1'b1;
            FZ_DEFER: if (!frz_act || !conv_busy) ctl.clr = 1'b1;
            default:  ctl.clr = 1'b1;
        endcase
        ctl.fire_ok = (state_q == FZ_RUN) && !frz_act && mode_timer;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FZ_RUN;
        else     state_q <= state_d;
    end

    assign state = state_q;

    // R6: a deferred freeze releases only through HOLD or RUN, never straight into DEFER again from HOLD
    a_r6_hold_not_defer: assert property (@(posedge clk) disable iff (rst)
        (state_q == FZ_HOLD) |=> (state_q != FZ_DEFER));
endmodule

// File: rtl/trig_tick_cnt.sv
module trig_tick_cnt #(
    parameter int CODE_W  = 4,
    parameter int MIN_EXP = 7,
    parameter int CNT_W   = MIN_EXP + (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              clr,
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  cnt,
    output logic              wrap
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    int               sh;

    always_comb begin
        sh   = trig_tmr_pkg::period_exp(MIN_EXP, int'(code));
        last = (ONE << sh) - ONE;
        wrap = en && !clr && (cnt_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (wrap)   cnt_q <= '0;
        else if (en)     cnt_q <= cnt_q + ONE;
    end

    assign cnt = cnt_q;

    // R2: without an enable or a clear the count is frozen
    a_r2_hold_without_en: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt_q));
    // R3: a wrap always lands on zero
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt_q == '0));
endmodule

// File: rtl/trig_pulse.sv
module trig_pulse (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic fire_ok,
    output logic trig
);
    always_ff @(posedge clk) begin
        if (rst) trig <= 1'b0;
        else     trig <= wrap && fire_ok;
    end
endmodule

// File: rtl/conv_trig_timer.sv
module conv_trig_timer
    import trig_tmr_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int MIN_EXP = 7,
    parameter int CNT_W   = MIN_EXP + (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              qclk_en,
    input  logic              mode_timer,
    input  logic [CODE_W-1:0] period_code,
    input  logic              frz_en,
    input  logic              sys_frz,
    input  logic              conv_busy,
    output logic              trig,
    output logic [CNT_W-1:0]  count
);
    logic       frz_act;
    logic       wrap;
    frz_state_e state;
    frz_ctl_t   ctl;

    assign frz_act = frz_en && sys_frz && mode_timer;

    trig_frz_ctl u_frz (
        .clk        (clk),
        .rst        (rst),
        .frz_act    (frz_act),
        .conv_busy  (conv_busy),
        .mode_timer (mode_timer),
        .state      (state),
        .ctl        (ctl)
    );

    trig_tick_cnt #(
        .CODE_W  (CODE_W),
        .MIN_EXP (MIN_EXP),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .en   (qclk_en),
        .clr  (ctl.clr),
        .code (period_code),
        .cnt  (count),
        .wrap (wrap)
    );

    trig_pulse u_pulse (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .fire_ok (ctl.fire_ok),
        .trig    (trig)
    );

    // R3: trigger is a single-cycle pulse
    a_r3_one_cycle_trig: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);
    // R5: freeze seen with no conversion in flight zeroes the count next cycle
    a_r5_hold_zero: assert property (@(posedge clk) disable iff (rst)
        (frz_act && !conv_busy) |=> (count == '0 && !trig));
    // R6: no trigger may leave while a deferred freeze is pending
    a_r6_no_trig_defer: assert property (@(posedge clk) disable iff (rst)
        (state == FZ_DEFER) |=> !trig);
    // R8: outside timer mode the count is zero and silent
    a_r8_mode_off: assert property (@(posedge clk) disable iff (rst)
        !mode_timer |=> (count == '0 && !trig));
endmodule

// File: tb/conv_trig_timer_tb.sv
`timescale 1ns/1ps
module conv_trig_timer_tb_top;
    localparam int CODE_W  = 2;
    localparam int MIN_EXP = 2;
    localparam int CNT_W   = MIN_EXP + (1 << CODE_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic qclk_en = 1'b0;
    logic mode_timer = 1'b1;
    logic [CODE_W-1:0] period_code = '0;
    logic frz_en = 1'b0;
    logic sys_frz = 1'b0;
    logic conv_busy = 1'b0;
    logic trig;
    logic [CNT_W-1:0] count;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    conv_trig_timer #(.CODE_W(CODE_W), .MIN_EXP(MIN_EXP)) dut_i (
        .clk(clk), .rst(rst), .qclk_en(qclk_en), .mode_timer(mode_timer),
        .period_code(period_code), .frz_en(frz_en), .sys_frz(sys_frz),
        .conv_busy(conv_busy), .trig(trig), .count(count)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic en);
        @(negedge clk);
        qclk_en = en;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        qclk_en = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 count", int'(count), 0);
        chk("R1 trig", int'(trig), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_en(input int k);
        for (int i = 0; i < k; i++) tick(1'b1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R2/R3: sweep every period code with several enable spacings
        for (int c = 0; c < (1 << CODE_W); c++) begin
            for (int pat = 1; pat <= 3; pat++) begin
                int p;
                int n;
                p = 1 << (MIN_EXP + c);
                n = 0;
                period_code = CODE_W'(c);
                do_reset();
                for (int cyc = 0; cyc < 2 * p * pat + 2; cyc++) begin
                    logic en;
                    en = (cyc % pat) == 0;
                    tick(en);
                    if (en) n++;
                    chk("R2 count", int'(count), n % p);
                    chk("R3 trig", int'(trig), (en && (n % p) == 0) ? 1 : 0);
                end
            end
        end

        // R4: freeze line ignored when freeze-enable is clear
        period_code = 0;
        do_reset();
        frz_en = 1'b0;
        sys_frz = 1'b1;
        for (int i = 1; i <= 10; i++) begin
            tick(1'b1);
            chk("R4 count", int'(count), i % 4);
            chk("R4 trig", int'(trig), (i % 4) == 0 ? 1 : 0);
        end
        sys_frz = 1'b0;

        // R5: immediate freeze, then R7 restart from zero
        period_code = 3;
        do_reset();
        run_en(5);
        chk("R5 pre", int'(count), 5);
        frz_en = 1'b1;
        sys_frz = 1'b1;
        conv_busy = 1'b0;
        tick(1'b1);
        chk("R5 cleared", int'(count), 0);
        for (int i = 0; i < 40; i++) begin
            tick(1'b1);
            chk("R5 held", int'(count), 0);
            chk("R5 trig", int'(trig), 0);
        end
        sys_frz = 1'b0;
        tick(1'b1);
        chk("R7 first", int'(count), 0);
        for (int i = 1; i <= 3; i++) begin
            tick(1'b1);
            chk("R7 resume", int'(count), i);
        end

        // R6: deferred freeze keeps counting without triggers
        do_reset();
        run_en(5);
        conv_busy = 1'b1;
        sys_frz = 1'b1;
        for (int i = 6; i <= 8; i++) begin
            tick(1'b1);
            chk("R6 counting", int'(count), i);
        end
        conv_busy = 1'b0;
        tick(1'b1);
        chk("R6 cleared", int'(count), 0);
        tick(1'b1);
        chk("R6 held", int'(count), 0);
        sys_frz = 1'b0;
        tick(1'b0);

        // R6: wrap during defer issues no trigger
        period_code = 0;
        do_reset();
        run_en(2);
        conv_busy = 1'b1;
        sys_frz = 1'b1;
        tick(1'b1);
        chk("R6 c3", int'(count), 3);
        chk("R6 t3", int'(trig), 0);
        tick(1'b1);
        chk("R6 wrap", int'(count), 0);
        chk("R6 nowrap trig", int'(trig), 0);
        tick(1'b1);
        chk("R6 c1", int'(count), 1);
        // R7: negation during defer restarts from zero
        sys_frz = 1'b0;
        tick(1'b1);
        chk("R7 defer release", int'(count), 0);
        tick(1'b1);
        chk("R7 defer resume", int'(count), 1);

        // R1: reset discards a pending deferred clear
        period_code = 3;
        do_reset();
        run_en(3);
        sys_frz = 1'b1;
        tick(1'b1);
        chk("R1 defer entered", int'(count), 4);
        sys_frz = 1'b0;
        do_reset();
        tick(1'b1);
        chk("R1 counts after reset", int'(count), 1);
        conv_busy = 1'b0;
        frz_en = 1'b0;

        // R8: timer mode off holds zero
        do_reset();
        run_en(4);
        mode_timer = 1'b0;
        for (int i = 0; i < 10; i++) begin
            tick(1'b1);
            chk("R8 count", int'(count), 0);
            chk("R8 trig", int'(trig), 0);
        end
        mode_timer = 1'b1;
        tick(1'b1);
        chk("R8 resume", int'(count), 1);

        // R9: lowering the period code past the count wraps at once
        period_code = 3;
        do_reset();
        run_en(20);
        chk("R9 pre", int'(count), 20);
        period_code = 0;
        tick(1'b1);
        chk("R9 wrap", int'(count), 0);
        chk("R9 trig", int'(trig), 1);
        tick(1'b1);
        chk("R9 after", int'(count), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule